// File: doc/BRIEF.md
# Load-Word Address Generator

This block sits in the execute stage of a core that decodes a 32-bit load-word instruction made of two 16-bit halfwords. Given the two halfwords, the current program counter and the values already read for the base and index registers, it works out which addressing form the instruction uses. It then produces the effective address, an optional new base value with its write enable, the destination register number and a flag that requests a user-level access.

The forms handled are literal addressing from an aligned program counter, register offset with a left shift of 0 to 3, a positive 12-bit immediate offset, a negative 8-bit offset, pre-indexed and post-indexed forms that write the base back, and the unprivileged form. Any other encoding of the selector field is reported as undefined. Every result is registered, so the outputs appear one cycle after a valid input.

Top module: `ldw_agen`

## Requirements
- R1: When the base field `instr_hi[3:0]` is 15, the address is the program counter rounded up to a multiple of 4, plus `instr_lo[11:0]` if `instr_hi[7]` is 1 and minus it if `instr_hi[7]` is 0. There is no write-back.
- R2: When the base field is not 15, `instr_hi[7]` is 0, selector `instr_lo[11:8]` is 0 and `instr_lo[7:6]` is 0, the address is the base plus the index shifted left by `instr_lo[5:4]`. There is no write-back.
- R3: Selectors 9 and 11 (hex B) are post-indexed. The address equals the base, and the written-back value is the base minus (9) or plus (B) the zero-extended `instr_lo[7:0]`.
- R4: Selector 12 (hex C) gives the base minus the zero-extended `instr_lo[7:0]`, with no write-back.
- R5: Selectors 13 (hex D, subtract) and 15 (hex F, add) are pre-indexed. The address is the base minus or plus the zero-extended `instr_lo[7:0]`, and the written-back value equals that address.
- R6: Selector 14 (hex E) gives the base plus the zero-extended `instr_lo[7:0]`, asserts `user_acc` and does not write back.
- R7: When the base field is not 15 and `instr_hi[7]` is 1, the address is the base plus the zero-extended `instr_lo[11:0]`, with no write-back.
- R8: With the base field not 15 and `instr_hi[7]` at 0, an undefined encoding asserts `undef` and keeps `out_valid` and `wb_en` low. The undefined encodings are selectors 1 to 8, selector 10 (hex A), and selector 0 with `instr_lo[7:6]` non-zero.
- R9: All outputs are registered one cycle behind `in_valid`. A cycle with `in_valid` low gives `out_valid`, `undef`, `wb_en` and `user_acc` low in the next cycle. A synchronous active-high `rst` clears every output.
- R10: `wb_en` is never asserted when the destination field `instr_lo[15:12]` equals the base field.
- R11: `dest_idx` carries `instr_lo[15:12]` and `wb_idx` carries the base field of the same instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr_hi | input | 16 | First halfword of the instruction |
| instr_lo | input | 16 | Second halfword of the instruction |
| pc | input | AW | Program counter value used for literal addressing |
| base_val | input | AW | Value of the base register |
| index_val | input | AW | Value of the index register |
| out_valid | output | 1 | A defined load was decoded in the previous cycle |
| undef | output | 1 | The instruction decoded in the previous cycle was undefined |
| eff_addr | output | AW | Effective address |
| wb_en | output | 1 | Write the base register back |
| wb_idx | output | 4 | Register number to write back |
| wb_data | output | AW | Value to write back |
| dest_idx | output | 4 | Destination register number |
| user_acc | output | 1 | Access must be performed at user level |

## Verification
The hardest case to reach from the ports is a write-back form whose destination equals its base. Write-back must then be suppressed while the address stays correct. Uniform random fields hit this only once in sixteen write-back draws, so the stimulus includes a directed pre-indexed case and a directed post-indexed case with the two fields equal. The random generator also biases the base field towards 15 and aims the selector at the defined values, so that literal rounding with both signs and every shift amount come up often. Borrow and carry at the 32-bit boundary are driven directly with a base near zero and a base near all ones.

// File: rtl/ldw_agen_pkg.sv
package ldw_agen_pkg;
   typedef enum logic [2:0] {
      FORM_LIT,
      FORM_REG,
      FORM_IMM12,
      FORM_POST,
      FORM_NEG,
      FORM_PRE,
      FORM_USER,
      FORM_UNDEF
   } ldw_form_e;
endpackage

// File: rtl/ldw_form_decode.sv
module ldw_form_decode
   import ldw_agen_pkg::*;
(
   input  logic [15:0] instr_hi,
   input  logic [15:0] instr_lo,
   output ldw_form_e   form,
   output logic        neg
);
   localparam logic [3:0] PC_REG = 4'hf;

   always_comb begin
      neg  = 1'b0;
      form = FORM_UNDEF;
      if (instr_hi[3:0] == PC_REG) begin
         form = FORM_LIT;
         neg  = ~instr_hi[7];
      end else if (instr_hi[7]) begin
         form = FORM_IMM12;
      end else begin
         unique case (instr_lo[11:8])
            4'h0: form = (instr_lo[7:6] == 2'b00) ? FORM_REG : FORM_UNDEF;
            4'h9: begin form = FORM_POST; neg = 1'b1; end
            4'hb: form = FORM_POST;
            4'hc: begin form = FORM_NEG;  neg = 1'b1; end
            4'hd: begin form = FORM_PRE;  neg = 1'b1; end
            4'hf: form = FORM_PRE;
            4'he: form = FORM_USER;
            default: form = FORM_UNDEF;
         endcase
      end
   end
endmodule

// File: rtl/ldw_addr_unit.sv
module ldw_addr_unit
   import ldw_agen_pkg::*;
#(
   parameter int AW        = 32,
   parameter int LIT_ALIGN = 4,
   parameter bit ROUND_UP  = 1'b1
)(
   input  ldw_form_e     form,
   input  logic          neg,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] base_val,
   input  logic [AW-1:0] index_val,
   input  logic [15:0]   instr_lo,
   output logic [AW-1:0] eff_addr,
   output logic [AW-1:0] wb_data,
   output logic          writes
);
   localparam logic [AW-1:0] ALIGN_MASK = AW'(LIT_ALIGN - 1);

   logic [AW-1:0] pc_al, imm12, imm8, scaled, base_off;

   generate
      if (ROUND_UP) begin : g_pc_up
         assign pc_al = (pc + ALIGN_MASK) & ~ALIGN_MASK;
      end else begin : g_pc_down
         assign pc_al = pc & ~ALIGN_MASK;
      end
   endgenerate

   assign imm12    = AW'(instr_lo[11:0]);
   assign imm8     = AW'(instr_lo[7:0]);
   assign scaled   = index_val << instr_lo[5:4];
   assign base_off = neg ? (base_val - imm8) : (base_val + imm8);
   assign writes   = (form == FORM_POST) || (form == FORM_PRE);

   always_comb begin
      wb_data  = base_off;
      unique case (form)
         FORM_LIT:   eff_addr = neg ? (pc_al - imm12) : (pc_al + imm12);
         FORM_REG:   eff_addr = base_val + scaled;
         FORM_IMM12: eff_addr = base_val + imm12;
         FORM_POST:  eff_addr = base_val;
         FORM_PRE,
         FORM_NEG,
         FORM_USER:  eff_addr = base_off;
         default:    eff_addr = '0;
      endcase
   end
endmodule

// File: rtl/ldw_agen.sv
module ldw_agen
   import ldw_agen_pkg::*;
#(
   parameter int AW        = 32,
   parameter int LIT_ALIGN = 4,
   parameter bit ROUND_UP  = 1'b1
)(
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [15:0]   instr_hi,
   input  logic [15:0]   instr_lo,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] base_val,
   input  logic [AW-1:0] index_val,
   output logic          out_valid,
   output logic          undef,
   output logic [AW-1:0] eff_addr,
   output logic          wb_en,
   output logic [3:0]    wb_idx,
   output logic [AW-1:0] wb_data,
   output logic [3:0]    dest_idx,
   output logic          user_acc
);
   generate
      if (AW < 16) begin : g_bad_aw
         $error("ldw_agen: AW must be at least 16");
      end
      if ((LIT_ALIGN < 2) || ((LIT_ALIGN & (LIT_ALIGN - 1)) != 0)) begin : g_bad_align
         $error("ldw_agen: LIT_ALIGN must be a power of two of at least 2");
      end
   endgenerate

   ldw_form_e     form;
   logic          neg, writes;
   logic [AW-1:0] addr_c, wb_c;

   ldw_form_decode u_dec (
      .instr_hi (instr_hi),
      .instr_lo (instr_lo),
      .form     (form),
      .neg      (neg)
   );

   ldw_addr_unit #(.AW(AW), .LIT_ALIGN(LIT_ALIGN), .ROUND_UP(ROUND_UP)) u_addr (
      .form      (form),
      .neg       (neg),
      .pc        (pc),
      .base_val  (base_val),
      .index_val (index_val),
      .instr_lo  (instr_lo),
      .eff_addr  (addr_c),
      .wb_data   (wb_c),
      .writes    (writes)
   );

   logic is_undef, same_reg;
   assign is_undef = (form == FORM_UNDEF);
   assign same_reg = (instr_lo[15:12] == instr_hi[3:0]);

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         undef     <= 1'b0;
         wb_en     <= 1'b0;
         user_acc  <= 1'b0;
         eff_addr  <= '0;
         wb_data   <= '0;
         wb_idx    <= '0;
         dest_idx  <= '0;
      end else begin
         out_valid <= in_valid & ~is_undef;
         undef     <= in_valid & is_undef;
         wb_en     <= in_valid & writes & ~same_reg;
         user_acc  <= in_valid & (form == FORM_USER);
         if (in_valid) begin
            eff_addr <= addr_c;
            wb_data  <= wb_c;
            wb_idx   <= instr_hi[3:0];
            dest_idx <= instr_lo[15:12];
         end
      end
   end
endmodule

// File: rtl/ldw_agen_chk.sv
module ldw_agen_chk #(
   parameter int AW = 32
)(
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic [15:0]   instr_hi,
   input logic [15:0]   instr_lo,
   input logic [AW-1:0] base_val,
   input logic          out_valid,
   input logic          undef,
   input logic [AW-1:0] eff_addr,
   input logic          wb_en,
   input logic [3:0]    wb_idx,
   input logic [AW-1:0] wb_data,
   input logic [3:0]    dest_idx,
   input logic          user_acc
);
   // R9
   lat_valid_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid || undef) |-> $past(in_valid));
   // R9
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && !undef && !wb_en && !user_acc));
   // R8
   undef_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      undef |-> (!out_valid && !wb_en && !user_acc));
   // R10
   wb_diff_chk: assert property (@(posedge clk) disable iff (rst)
      wb_en |-> (wb_idx != dest_idx));
   // R6
   user_nowb_chk: assert property (@(posedge clk) disable iff (rst)
      user_acc |-> (out_valid && !wb_en));
   // R5
   pre_match_chk: assert property (@(posedge clk) disable iff (rst)
      (wb_en && $past(instr_lo[10])) |-> (wb_data == eff_addr));
   // R3
   post_base_chk: assert property (@(posedge clk) disable iff (rst)
      (wb_en && !$past(instr_lo[10])) |-> (eff_addr == $past(base_val)));
   // R1
   lit_nowb_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(instr_hi[3:0]) == 4'hf) |-> !wb_en);
endmodule

bind ldw_agen ldw_agen_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .instr_hi  (instr_hi),
   .instr_lo  (instr_lo),
   .base_val  (base_val),
   .out_valid (out_valid),
   .undef     (undef),
   .eff_addr  (eff_addr),
   .wb_en     (wb_en),
   .wb_idx    (wb_idx),
   .wb_data   (wb_data),
   .dest_idx  (dest_idx),
   .user_acc  (user_acc)
);

// File: tb/sim_ldw_agen.sv
module sim_ldw_agen;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [15:0] instr_hi = '0, instr_lo = '0;
   logic [31:0] pc = '0, base_val = '0, index_val = '0;
   logic        out_valid, undef, wb_en, user_acc;
   logic [31:0] eff_addr, wb_data;
   logic [3:0]  wb_idx, dest_idx;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #(CLK_P/2) clk = ~clk;

   ldw_agen u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .instr_hi(instr_hi),
      .instr_lo(instr_lo), .pc(pc), .base_val(base_val), .index_val(index_val),
      .out_valid(out_valid), .undef(undef), .eff_addr(eff_addr), .wb_en(wb_en),
      .wb_idx(wb_idx), .wb_data(wb_data), .dest_idx(dest_idx), .user_acc(user_acc)
   );

   // expected values
   logic        e_valid, e_undef, e_wb, e_user;
   logic [31:0] e_addr, e_wbd;
   string       e_req;

   task automatic model(input logic [15:0] hi, input logic [15:0] lo,
                        input logic [31:0] p, input logic [31:0] b, input logic [31:0] x);
      logic [31:0] i12, i8, pa;
      i12 = {20'd0, lo[11:0]};
      i8  = {24'd0, lo[7:0]};
      pa  = (p + 32'd3) & 32'hffff_fffc;
      e_valid = 1; e_undef = 0; e_wb = 0; e_user = 0; e_wbd = 0; e_addr = 0;
      if (hi[3:0] == 4'hf) begin
         e_req = "R1"; e_addr = hi[7] ? pa + i12 : pa - i12;
      end else if (hi[7]) begin
         e_req = "R7"; e_addr = b + i12;
      end else begin
         case (lo[11:8])
            4'h0: if (lo[7:6] == 0) begin e_req = "R2"; e_addr = b + (x << lo[5:4]); end
                  else begin e_req = "R8"; e_valid = 0; e_undef = 1; end
            4'h9: begin e_req = "R3"; e_addr = b; e_wb = 1; e_wbd = b - i8; end
            4'hb: begin e_req = "R3"; e_addr = b; e_wb = 1; e_wbd = b + i8; end
            4'hc: begin e_req = "R4"; e_addr = b - i8; end
            4'hd: begin e_req = "R5"; e_addr = b - i8; e_wb = 1; e_wbd = b - i8; end
            4'hf: begin e_req = "R5"; e_addr = b + i8; e_wb = 1; e_wbd = b + i8; end
            4'he: begin e_req = "R6"; e_addr = b + i8; e_user = 1; end
            default: begin e_req = "R8"; e_valid = 0; e_undef = 1; end
         endcase
      end
      if (e_wb && lo[15:12] == hi[3:0]) begin e_wb = 0; e_req = {e_req, "/R10"}; end
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [15:0] hi, input logic [15:0] lo,
                        input logic [31:0] p, input logic [31:0] b, input logic [31:0] x);
      @(negedge clk);
      instr_hi = hi; instr_lo = lo; pc = p; base_val = b; index_val = x; in_valid = 1;
      model(hi, lo, p, b, x);
      @(negedge clk);
      chk(e_req, "out_valid", {31'd0, out_valid}, {31'd0, e_valid});
      chk(e_req, "undef",     {31'd0, undef},     {31'd0, e_undef});
      chk(e_req, "wb_en",     {31'd0, wb_en},     {31'd0, e_wb});
      chk(e_req, "user_acc",  {31'd0, user_acc},  {31'd0, e_user});
      if (e_valid) begin
         chk(e_req, "eff_addr", eff_addr, e_addr);
         chk("R11", "dest_idx", {28'd0, dest_idx}, {28'd0, lo[15:12]});
      end
      if (e_wb) begin
         chk(e_req, "wb_data", wb_data, e_wbd);
         chk("R11", "wb_idx", {28'd0, wb_idx}, {28'd0, hi[3:0]});
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9", "rst out_valid", {31'd0, out_valid}, 32'd0);
      chk("R9", "rst wb_en", {31'd0, wb_en}, 32'd0);
      chk("R9", "rst eff_addr", eff_addr, 32'd0);
      rst = 0;
      // R1 literal: round up, both signs
      apply(16'h008f, 16'h3010, 32'h0000_1001, 32'h0, 32'h0);
      apply(16'h000f, 16'h3010, 32'h0000_1003, 32'h0, 32'h0);
      apply(16'h008f, 16'h3fff, 32'h0000_2000, 32'h0, 32'h0);
      // R2 register offset, every shift amount
      for (int s = 0; s < 4; s++)
         apply(16'h0002, {4'h1, 4'h0, 2'b00, s[1:0], 4'h3}, 0, 32'h100, 32'h0000_0013);
      // R3 post-index, base near zero borrow
      apply(16'h0004, 16'h29ff, 0, 32'h0000_0010, 0);
      apply(16'h0004, 16'h2b80, 0, 32'hffff_ffc0, 0);
      // R4, R5, R6
      apply(16'h0005, 16'h3c21, 0, 32'h0000_0100, 0);
      apply(16'h0005, 16'h3d21, 0, 32'h0000_0100, 0);
      apply(16'h0005, 16'h3f21, 0, 32'hffff_fff0, 0);
      apply(16'h0005, 16'h3e21, 0, 32'h0000_0100, 0);
      // R7 positive imm12
      apply(16'h0086, 16'h4abc, 0, 32'h1000_0000, 0);
      // R8 undefined selectors
      apply(16'h0006, 16'h4500, 0, 32'h1, 0);
      apply(16'h0006, 16'h4a00, 0, 32'h1, 0);
      apply(16'h0006, 16'h4040, 0, 32'h1, 0);
      // R10 dest equals base, pre and post
      apply(16'h0007, 16'h7f08, 0, 32'h200, 0);
      apply(16'h0007, 16'h7908, 0, 32'h200, 0);
      // R9 idle cycle clears flags
      @(negedge clk); in_valid = 0;
      @(negedge clk);
      chk("R9", "idle out_valid", {31'd0, out_valid}, 32'd0);
      chk("R9", "idle undef", {31'd0, undef}, 32'd0);
      // constrained random
      for (int n = 0; n < 600; n++) begin
         logic [15:0] hi, lo;
         logic [3:0]  sels [8];
         sels = '{4'h0, 4'h9, 4'hb, 4'hc, 4'hd, 4'he, 4'hf, 4'h3};
         hi = 16'($urandom);
         lo = 16'($urandom);
         if ($urandom_range(0, 3) == 0) hi[3:0] = 4'hf;
         else if (hi[3:0] == 4'hf) hi[3:0] = 4'h1;
         if ($urandom_range(0, 1) == 0) hi[7] = 0;
         lo[11:8] = sels[$urandom_range(0, 7)];
         if (lo[11:8] == 0 && $urandom_range(0, 1) == 0) lo[7:6] = 0;
         apply(hi, lo, $urandom, $urandom, $urandom);
      end
      // R9 reset clears after activity
      @(negedge clk); rst = 1;
      @(negedge clk);
      chk("R9", "rst2 out_valid", {31'd0, out_valid}, 32'd0);
      chk("R9", "rst2 dest_idx", {28'd0, dest_idx}, 32'd0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule